// File: doc/BRIEF.md
# Modem Status Edge Detector

This block serves the modem-control side of a serial port. Four asynchronous status lines (ring indicator, clear-to-send, carrier detect, data-set-ready) are brought into the clock domain through a multi-flop synchroniser, and their levels are presented as a four-bit vector. Two of the lines, clear-to-send and carrier detect, also feed edge detectors. Each detector latches a sticky status bit. A per-line sense option selects between rising edges only and edges of either polarity.

The latched edge statuses are held until the status vector is read. A one-cycle read strobe clears them. The statuses enabled by a per-line mask are OR-ed into one pending flag, which acts as the external-input source of the port's main interrupt register. That flag is gated by its own enable to form the interrupt output. A three-bit control register holds the terminal-ready and request-to-send bits, which appear inverted on their pins, and a loopback control bit.

Top module: `modem_status_edge`

## Requirements
- R1: `line_lvl_o` bit 0 = ring indicator, bit 1 = clear-to-send, bit 2 = carrier detect, bit 3 = data-set-ready. Each bit follows its pin after exactly two rising clock edges, and not after one.
- R2: With the sense bit clear (`any_edge_i[k]` = 0), a rising edge sets `edge_stat_o[k]` (bit 0 = clear-to-send, bit 1 = carrier detect). A falling edge leaves it clear.
- R3: With the sense bit set (`any_edge_i[k]` = 1), both rising and falling edges set `edge_stat_o[k]`.
- R4: A cycle with `stat_rd_i` = 1 clears every edge status bit on the following clock edge.
- R5: An edge detected in the same cycle as a clearing read leaves that status bit set.
- R6: `ext_pend_o` is the OR of `edge_stat_o & edge_mask_i`. A status bit latches whatever its mask bit is.
- R7: `ext_irq_o` is `ext_pend_o` AND `ext_irq_en_i`.
- R8: `mctl_wdata_i` bit 0 = terminal ready, bit 1 = request to send, bit 2 = loopback. After a write, `dtr_pin_o` and `rts_pin_o` show the inverse of the written bits.
- R9: `loopback_o` shows the written loopback bit.
- R10: After reset the status bits, the level vector, `ext_pend_o`, `ext_irq_o` and `loopback_o` are 0, and both control pins are 1.
- R11: A set edge status bit holds without a read, through any number of further input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ri_i | input | 1 | Ring indicator line, asynchronous |
| cts_i | input | 1 | Clear-to-send line, asynchronous |
| dcd_i | input | 1 | Carrier-detect line, asynchronous |
| dsr_i | input | 1 | Data-set-ready line, asynchronous |
| edge_mask_i | input | 2 | Edge status enables for the pending flag |
| any_edge_i | input | 2 | Per-line sense: 1 = either edge, 0 = rising only |
| ext_irq_en_i | input | 1 | Enable of the external-input interrupt source |
| stat_rd_i | input | 1 | Read strobe of the status vector, clears it |
| mctl_we_i | input | 1 | Write strobe of the control register |
| mctl_wdata_i | input | 3 | Control write data {loopback, rts, dtr} |
| line_lvl_o | output | 4 | Synchronised line levels |
| edge_stat_o | output | 2 | Latched edge statuses |
| ext_pend_o | output | 1 | OR of enabled edge statuses |
| ext_irq_o | output | 1 | Gated external-input interrupt |
| dtr_pin_o | output | 1 | Terminal-ready pin, inverse of control bit |
| rts_pin_o | output | 1 | Request-to-send pin, inverse of control bit |
| loopback_o | output | 1 | Loopback control |

## Verification
A pin change shows on the level vector two clock edges after it is driven. It reaches the edge status one edge later. The pending and interrupt flags follow the status and their enables without delay. A control write and a clearing read both take effect on the next edge. The bench drives every input on a falling clock edge and counts rising edges from that point before sampling on a later falling edge. Level checks also sample one edge early, to show the value has not yet moved. The coincident-read case places the read strobe exactly in the cycle in which the detector sees its edge.

// File: rtl/msed_pkg.sv
package msed_pkg;
  localparam int LINE_W = 4;
  localparam int EDGE_W = 2;
  localparam int MCTL_W = 3;

  localparam int IDX_RI  = 0;
  localparam int IDX_CTS = 1;
  localparam int IDX_DCD = 2;
  localparam int IDX_DSR = 3;

  typedef struct packed {
    logic loop;
    logic rts;
    logic dtr;
  } mctl_t;

  // line index watched by edge detector k
  function automatic int edge_line(input int k);
    return (k == 0) ? IDX_CTS : IDX_DCD;
  endfunction
endpackage

// File: rtl/msed_sync.sv
module msed_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [STAGES-1:0][WIDTH-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) chain_q[i] <= chain_q[i-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage_chk
      assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[g] == $past(chain_q[g-1]));
    end
  endgenerate
endmodule

// File: rtl/msed_edge_cell.sv
module msed_edge_cell (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic any_edge_i,
  input  logic clr_i,
  output logic stat_o
);
  logic prev_q, stat_q, stat_d, hit;

  always_comb begin
    hit    = any_edge_i ? (lvl_i ^ prev_q) : (lvl_i & ~prev_q);
    stat_d = hit | (stat_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      stat_q <= 1'b0;
    end else begin
      prev_q <= lvl_i;
      stat_q <= stat_d;
    end
  end

  assign stat_o = stat_q;

  assert_set_by_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_q) |-> $past(lvl_i != prev_q));
  assert_no_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!any_edge_i && !lvl_i && prev_q && !stat_q) |=> !stat_q);
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q && !clr_i) |=> stat_q);
  assert_edge_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && any_edge_i && (lvl_i != prev_q)) |=> stat_q);
  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && (lvl_i == prev_q)) |=> !stat_q);
endmodule

// File: rtl/msed_mctl.sv
module msed_mctl
  import msed_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  we_i,
  input  mctl_t wdata_i,
  output logic  dtr_pin_o,
  output logic  rts_pin_o,
  output logic  loop_o
);
  mctl_t ctl_q, ctl_d;

  always_comb begin
    ctl_d = ctl_q;
    if (we_i) ctl_d = wdata_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= '0;
    else        ctl_q <= ctl_d;
  end

  assign dtr_pin_o = ~ctl_q.dtr;
  assign rts_pin_o = ~ctl_q.rts;
  assign loop_o    = ctl_q.loop;

  assert_pins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> (dtr_pin_o == !$past(wdata_i.dtr)) && (rts_pin_o == !$past(wdata_i.rts)));
  assert_loop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    we_i |=> loop_o == $past(wdata_i.loop));
endmodule

// File: rtl/modem_status_edge.sv
module modem_status_edge
  import msed_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ri_i,
  input  logic              cts_i,
  input  logic              dcd_i,
  input  logic              dsr_i,
  input  logic [EDGE_W-1:0] edge_mask_i,
  input  logic [EDGE_W-1:0] any_edge_i,
  input  logic              ext_irq_en_i,
  input  logic              stat_rd_i,
  input  logic              mctl_we_i,
  input  logic [MCTL_W-1:0] mctl_wdata_i,
  output logic [LINE_W-1:0] line_lvl_o,
  output logic [EDGE_W-1:0] edge_stat_o,
  output logic              ext_pend_o,
  output logic              ext_irq_o,
  output logic              dtr_pin_o,
  output logic              rts_pin_o,
  output logic              loopback_o
);
  logic [1:0]        rst_sync_q;
  logic              rst_int_n;
  logic [LINE_W-1:0] raw_lines;
  logic [LINE_W-1:0] lvl;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  always_comb begin
    raw_lines          = '0;
    raw_lines[IDX_RI]  = ri_i;
    raw_lines[IDX_CTS] = cts_i;
    raw_lines[IDX_DCD] = dcd_i;
    raw_lines[IDX_DSR] = dsr_i;
  end

  msed_sync #(.WIDTH(LINE_W), .STAGES(SYNC_STAGES)) i_sync (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .async_i(raw_lines),
    .sync_o (lvl)
  );

  assign line_lvl_o = lvl;

  generate
    for (genvar k = 0; k < EDGE_W; k++) begin : g_edge
      msed_edge_cell i_cell (
        .clk       (clk),
        .rst_n     (rst_int_n),
        .lvl_i     (lvl[edge_line(k)]),
        .any_edge_i(any_edge_i[k]),
        .clr_i     (stat_rd_i),
        .stat_o    (edge_stat_o[k])
      );
    end
  endgenerate

  assign ext_pend_o = |(edge_stat_o & edge_mask_i);
  assign ext_irq_o  = ext_pend_o & ext_irq_en_i;

  msed_mctl i_mctl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .we_i     (mctl_we_i),
    .wdata_i  (mctl_t'(mctl_wdata_i)),
    .dtr_pin_o(dtr_pin_o),
    .rts_pin_o(rts_pin_o),
    .loop_o   (loopback_o)
  );

  assert_irq_gate_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    ext_irq_o |-> (ext_pend_o && ext_irq_en_i));
  assert_pend_src_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    ext_pend_o |-> (edge_stat_o != '0));
endmodule

// File: tb/test_modem_status_edge.sv
module test_modem_status_edge;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ri, cts, dcd, dsr;
  logic [1:0] emask, anye;
  logic       irq_en, rd, we;
  logic [2:0] wdata;
  logic [3:0] lvl;
  logic [1:0] stat;
  logic       pend, irq, dtr_pin, rts_pin, loopb;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  modem_status_edge i_modem_status_edge (
    .clk(clk), .rst_n(rst_n), .ri_i(ri), .cts_i(cts), .dcd_i(dcd), .dsr_i(dsr),
    .edge_mask_i(emask), .any_edge_i(anye), .ext_irq_en_i(irq_en),
    .stat_rd_i(rd), .mctl_we_i(we), .mctl_wdata_i(wdata),
    .line_lvl_o(lvl), .edge_stat_o(stat), .ext_pend_o(pend), .ext_irq_o(irq),
    .dtr_pin_o(dtr_pin), .rts_pin_o(rts_pin), .loopback_o(loopb)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clear_stat();
    rd = 1'b1; tick(1); rd = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 stat", stat, 0);
    chk("R10 lvl", lvl, 0);
    chk("R10 pend", pend, 0);
    chk("R10 irq", irq, 0);
    chk("R10 dtr pin", dtr_pin, 1);
    chk("R10 rts pin", rts_pin, 1);
    chk("R10 loop", loopb, 0);
  endtask

  task automatic t_levels();
    ri = 1; tick(1);
    chk("R1 ri not yet", lvl, 4'b0000);
    tick(1);
    chk("R1 ri", lvl, 4'b0001);
    dsr = 1; cts = 1; tick(2);
    chk("R1 dsr+cts", lvl, 4'b1011);
    dcd = 1; ri = 0; tick(2);
    chk("R1 dcd", lvl, 4'b1110);
    ri = 0; cts = 0; dcd = 0; dsr = 0; tick(4);
    chk("R1 all low", lvl, 4'b0000);
    clear_stat(); tick(1);
    chk("R4 cleared after levels", stat, 0);
  endtask

  task automatic t_rising();
    anye = 2'b00;
    cts = 1; tick(2);
    chk("R2 not before detect", stat, 2'b00);
    tick(1);
    chk("R2 cts rise", stat, 2'b01);
    clear_stat();
    chk("R4 clear", stat, 2'b00);
    cts = 0; tick(5);
    chk("R2 cts fall ignored", stat, 2'b00);
  endtask

  task automatic t_any();
    anye = 2'b10;
    dcd = 1; tick(3);
    chk("R3 dcd rise", stat, 2'b10);
    clear_stat();
    chk("R4 clear dcd", stat, 2'b00);
    dcd = 0; tick(3);
    chk("R3 dcd fall", stat, 2'b10);
    dcd = 1; tick(3); dcd = 0; tick(5);
    chk("R11 sticky", stat, 2'b10);
  endtask

  task automatic t_pend();
    emask = 2'b00; irq_en = 0; #1;
    chk("R6 masked pend", pend, 0);
    chk("R6 stat kept", stat, 2'b10);
    emask = 2'b01; #1;
    chk("R6 other mask", pend, 0);
    emask = 2'b10; #1;
    chk("R6 pend", pend, 1);
    chk("R7 irq off", irq, 0);
    irq_en = 1; #1;
    chk("R7 irq on", irq, 1);
    tick(1);
    clear_stat(); #1;
    chk("R6 pend after clear", pend, 0);
    chk("R7 irq after clear", irq, 0);
  endtask

  task automatic t_coincide();
    anye = 2'b11;
    cts = 1; dcd = 1; tick(3);
    chk("R3 both set", stat, 2'b11);
    cts = 0; tick(2);
    rd = 1; tick(1); rd = 0;
    chk("R5 edge beats read", stat, 2'b01);
    clear_stat();
    chk("R4 final clear", stat, 2'b00);
    dcd = 0; tick(3); clear_stat();
  endtask

  task automatic t_mctl();
    wdata = 3'b101; we = 1; tick(1); we = 0;
    chk("R8 dtr pin", dtr_pin, 0);
    chk("R8 rts pin", rts_pin, 1);
    chk("R9 loop on", loopb, 1);
    wdata = 3'b010; we = 1; tick(1); we = 0;
    chk("R8 dtr pin 2", dtr_pin, 1);
    chk("R8 rts pin 2", rts_pin, 0);
    chk("R9 loop off", loopb, 0);
  endtask

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 0; ri = 0; cts = 0; dcd = 0; dsr = 0;
    emask = 0; anye = 0; irq_en = 0; rd = 0; we = 0; wdata = 0;
    tick(3);
    rst_n = 1;
    tick(3);
    t_reset();
    t_levels();
    t_rising();
    t_any();
    t_pend();
    t_coincide();
    t_mctl();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule